// File: doc/BRIEF.md
# Power-Transition Packet Spacing Monitor

This block is a passive observer for a shared memory channel that carries decoded row and column command packets to several devices. It does not drive the channel. It follows each device through its power transitions, records the cycle at which each transition was requested, and checks every later packet against the timing windows around that transition. When a packet breaks a spacing rule, the block raises a one-cycle violation flag together with a reason code. It also flags packets that reach a device after that device has gone to sleep, because the device will drop them.

Two kinds of transition are followed. A standby request is a directed row packet with the relax bit set. Its transition frame falls `T_FRM` cycles after the request. A low-power entry (nap or power-down) is a directed row packet that carries the matching opcode. After it come a restricted window and, nested inside that window, a quiet window. Once the restricted window ends, the device counts as asleep until a wake strobe for that device is seen. Each device has one tracker, and that tracker holds only the most recent accepted transition.

Top module: `pwr_gap_monitor`

## Requirements
- R1: While reset is high and on the first cycle after it, `viol`, `viol_code` and `ign` are all 0, and every device is idle.
- R2: Take a standby request accepted in cycle s. A column packet to any device at age 5, 6 or 7 after it (ages `T_FRM`-3 to `T_FRM`-1, with `T_FRM`=8) raises reason code 1 (forbidden column slot).
- R3: Take the same request. A column packet at age 4 or earlier, or at age 8 or later, raises no violation under the standby rules.
- R4: A standby request (`row_rlx`=1) must be directed (`row_bcast`=0) and carry opcode 0 (activate), 1 (restore) or 2 (attention). A nap (opcode 4) or power-down (opcode 5) request must be directed. A malformed request raises code 4 (bad setup) and arms nothing.
- R5: Take a low-power entry accepted in cycle s. A directed row packet or a column packet to that same device at ages 1 to `RESTR_LEN` (10) raises code 2 (restricted overlap). Packets to other devices in that window raise nothing.
- R6: A broadcast row packet at ages `QUIET_OFS`+1 to `QUIET_OFS`+`QUIET_LEN` (4 to 7) of any entering device raises code 3 (broadcast in quiet window). A broadcast row packet at other ages of the restricted window raises nothing.
- R7: From age `RESTR_LEN`+1 on, a directed row packet or a column packet to that device sets `ign` one cycle later and raises no violation. A setup request to an asleep device arms nothing.
- R8: A wake strobe for an asleep device returns it to idle, and its packets stop being ignored. A wake strobe for a device that is not asleep has no effect.
- R9: When several reasons apply in the same cycle, exactly one code is reported. The order is 1 over 2, 2 over 3, and 3 over 4.
- R10: A setup request to a device inside its restricted window raises code 2 and does not restart that device's timing. A valid standby request to a device that is already waiting for standby restarts the frame.
- R11: Every flag is registered. It appears in the cycle after the offending packet and lasts one cycle. `viol_code` is 0 whenever `viol` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Channel clock |
| rst | input | 1 | Synchronous active-high reset |
| row_vld | input | 1 | A row packet is present this cycle |
| row_dev | input | DEV_W | Target device of the row packet |
| row_op | input | 3 | Row opcode class: 0 act, 1 restore, 2 attention, 3 precharge, 4 nap, 5 power-down, 6 refresh, 7 other |
| row_bcast | input | 1 | The row packet is broadcast to all devices |
| row_rlx | input | 1 | The row packet requests standby entry |
| col_vld | input | 1 | A column packet is present this cycle |
| col_dev | input | DEV_W | Target device of the column packet |
| wake_vld | input | 1 | A wake-up sequence was seen this cycle |
| wake_dev | input | DEV_W | Device that is being woken |
| viol | output | 1 | One-cycle violation pulse |
| viol_code | output | 3 | Reason: 1 slot, 2 restricted, 3 quiet, 4 setup, 0 none |
| ign | output | 1 | The previous cycle's packet will be dropped by a sleeping device |

## Verification
On every cycle, the assertions tie the per-device window flags to the reported outcome. A column packet in a forbidden slot must produce code 1. A column packet in a device's restricted window must produce code 2 when no slot rule applies. A qualifying broadcast must produce code 3. A column packet to a sleeping device must set `ign`. Every pulse must have a packet behind it, and each quiet window must lie inside its restricted window. The assertions cannot show that the windows open at the right ages, that malformed requests arm nothing, or that wake strobes and restarts behave correctly. Those behaviours appear only in the bench's scenarios, where a behavioural model follows each device's request cycle and compares all three outputs on every clock.

// File: rtl/pwr_gap_pkg.sv
package pwr_gap_pkg;

    typedef enum logic [2:0] {
        OP_ACT     = 3'd0,
        OP_RESTORE = 3'd1,
        OP_ATTN    = 3'd2,
        OP_PRECH   = 3'd3,
        OP_NAP     = 3'd4,
        OP_PDN     = 3'd5,
        OP_REFR    = 3'd6,
        OP_OTHER   = 3'd7
    } row_op_e;

    typedef enum logic [2:0] {
        VC_NONE  = 3'd0,
        VC_SLOT  = 3'd1,
        VC_RESTR = 3'd2,
        VC_QUIET = 3'd3,
        VC_SETUP = 3'd4
    } viol_e;

    typedef enum logic [1:0] {
        DS_IDLE,
        DS_STBY,
        DS_ENTER,
        DS_ASLEEP
    } dev_state_e;

    typedef struct packed {
        logic forbid;
        logic restr;
        logic quiet;
        logic asleep;
    } dev_flags_t;

    typedef struct packed {
        logic    is_setup;
        logic    malformed;
        logic    to_stby;
    } setup_info_t;

    function automatic logic stby_op_ok(row_op_e op);
        return (op == OP_ACT) || (op == OP_RESTORE) || (op == OP_ATTN);
    endfunction

    function automatic logic is_low_power(row_op_e op);
        return (op == OP_NAP) || (op == OP_PDN);
    endfunction

    function automatic setup_info_t classify_setup(row_op_e op, logic bcast, logic rlx);
        setup_info_t s;
        s.is_setup  = rlx || is_low_power(op);
        s.malformed = bcast || (rlx && !stby_op_ok(op));
        s.to_stby   = rlx;
        return s;
    endfunction

endpackage

// File: rtl/pwr_gap_dev_track.sv
module pwr_gap_dev_track
    import pwr_gap_pkg::*;
#(
    parameter int CNT_W     = 6,
    parameter int T_FRM     = 8,
    parameter int RESTR_LEN = 10,
    parameter int QUIET_OFS = 3,
    parameter int QUIET_LEN = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] now,
    input  logic             arm_stby,
    input  logic             arm_pwr,
    input  logic             wake,
    output dev_flags_t       flags
);
    localparam logic [CNT_W-1:0] SLOT_LO  = CNT_W'(T_FRM - 3);
    localparam logic [CNT_W-1:0] SLOT_HI  = CNT_W'(T_FRM - 1);
    localparam logic [CNT_W-1:0] R_LAST   = CNT_W'(RESTR_LEN);
    localparam logic [CNT_W-1:0] Q_FIRST  = CNT_W'(QUIET_OFS + 1);
    localparam logic [CNT_W-1:0] Q_LAST   = CNT_W'(QUIET_OFS + QUIET_LEN);

    dev_state_e       state_q;
    logic [CNT_W-1:0] stamp_q;
    logic [CNT_W-1:0] age;

    assign age = now - stamp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= DS_IDLE;
            stamp_q <= '0;
        end else if (arm_stby) begin
            state_q <= DS_STBY;
            stamp_q <= now;
        end else if (arm_pwr) begin
            state_q <= DS_ENTER;
            stamp_q <= now;
        end else begin
            case (state_q)
                DS_STBY:   if (age == SLOT_HI) state_q <= DS_IDLE;
                DS_ENTER:  if (age == R_LAST)  state_q <= DS_ASLEEP;
                DS_ASLEEP: if (wake)           state_q <= DS_IDLE;
                default:   state_q <= DS_IDLE;
            endcase
        end
    end

    always_comb begin
        flags.forbid = (state_q == DS_STBY) && (age >= SLOT_LO) && (age <= SLOT_HI);
        flags.restr  = (state_q == DS_ENTER) && (age != '0) && (age <= R_LAST);
        flags.quiet  = (state_q == DS_ENTER) && (age >= Q_FIRST) && (age <= Q_LAST);
        flags.asleep = (state_q == DS_ASLEEP);
    end

endmodule

// File: rtl/pwr_gap_pkt_eval.sv
module pwr_gap_pkt_eval
    import pwr_gap_pkg::*;
#(
    parameter int DEV_W = 4,
    parameter int N_DEV = 16
) (
    input  logic             row_vld,
    input  logic [DEV_W-1:0] row_dev,
    input  row_op_e          row_op,
    input  logic             row_bcast,
    input  logic             row_rlx,
    input  logic             col_vld,
    input  logic [DEV_W-1:0] col_dev,
    input  logic             wake_vld,
    input  logic [DEV_W-1:0] wake_dev,
    input  logic [N_DEV-1:0] forbid_v,
    input  logic [N_DEV-1:0] restr_v,
    input  logic [N_DEV-1:0] quiet_v,
    input  logic [N_DEV-1:0] asleep_v,
    output viol_e            code,
    output logic             ign,
    output logic [N_DEV-1:0] arm_stby_v,
    output logic [N_DEV-1:0] arm_pwr_v,
    output logic [N_DEV-1:0] wake_v
);
    setup_info_t si;
    logic row_dir;
    logic col_slot, restr_hit, quiet_hit, setup_bad, setup_ok;

    always_comb begin
        si        = classify_setup(row_op, row_bcast, row_rlx);
        row_dir   = row_vld && !row_bcast;
        col_slot  = col_vld && (|forbid_v);
        restr_hit = (row_dir && restr_v[row_dev]) || (col_vld && restr_v[col_dev]);
        quiet_hit = row_vld && row_bcast && (|quiet_v);
        setup_bad = row_vld && si.is_setup && si.malformed
                    && !(row_dir && asleep_v[row_dev]);
        setup_ok  = row_dir && si.is_setup && !si.malformed
                    && !restr_v[row_dev] && !asleep_v[row_dev];

        if (col_slot)       code = VC_SLOT;
        else if (restr_hit) code = VC_RESTR;
        else if (quiet_hit) code = VC_QUIET;
        else if (setup_bad) code = VC_SETUP;
        else                code = VC_NONE;

        ign = (row_dir && asleep_v[row_dev]) || (col_vld && asleep_v[col_dev]);
    end

    for (genvar g = 0; g < N_DEV; g++) begin : g_dec
        assign arm_stby_v[g] = setup_ok && si.to_stby  && (row_dev == DEV_W'(g));
        assign arm_pwr_v[g]  = setup_ok && !si.to_stby && (row_dev == DEV_W'(g));
        assign wake_v[g]     = wake_vld && (wake_dev == DEV_W'(g));
    end

endmodule

// File: rtl/pwr_gap_monitor.sv
module pwr_gap_monitor
    import pwr_gap_pkg::*;
#(
    parameter int DEV_W     = 4,
    parameter int T_FRM     = 8,
    parameter int RESTR_LEN = 10,
    parameter int QUIET_OFS = 3,
    parameter int QUIET_LEN = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             row_vld,
    input  logic [DEV_W-1:0] row_dev,
    input  logic [2:0]       row_op,
    input  logic             row_bcast,
    input  logic             row_rlx,
    input  logic             col_vld,
    input  logic [DEV_W-1:0] col_dev,
    input  logic             wake_vld,
    input  logic [DEV_W-1:0] wake_dev,
    output logic             viol,
    output logic [2:0]       viol_code,
    output logic             ign
);
    localparam int N_DEV = 1 << DEV_W;
    localparam int SPAN  = (T_FRM > RESTR_LEN) ? T_FRM : RESTR_LEN;
    localparam int CNT_W = $clog2(SPAN + 2) + 1;

    logic [CNT_W-1:0] now_q;
    logic [N_DEV-1:0] forbid_v, restr_v, quiet_v, asleep_v;
    logic [N_DEV-1:0] arm_stby_v, arm_pwr_v, wake_v;
    viol_e            nxt_code;
    logic             nxt_ign;
    viol_e            code_q;
    logic             ign_q;

    always_ff @(posedge clk) begin
        if (rst) now_q <= '0;
        else     now_q <= now_q + 1'b1;
    end

    for (genvar g = 0; g < N_DEV; g++) begin : g_dev
        dev_flags_t fl;
        pwr_gap_dev_track #(
            .CNT_W(CNT_W), .T_FRM(T_FRM), .RESTR_LEN(RESTR_LEN),
            .QUIET_OFS(QUIET_OFS), .QUIET_LEN(QUIET_LEN)
        ) u_trk (
            .clk(clk), .rst(rst), .now(now_q),
            .arm_stby(arm_stby_v[g]), .arm_pwr(arm_pwr_v[g]),
            .wake(wake_v[g]), .flags(fl)
        );
        assign forbid_v[g] = fl.forbid;
        assign restr_v[g]  = fl.restr;
        assign quiet_v[g]  = fl.quiet;
        assign asleep_v[g] = fl.asleep;
    end

    pwr_gap_pkt_eval #(.DEV_W(DEV_W), .N_DEV(N_DEV)) u_eval (
        .row_vld(row_vld), .row_dev(row_dev), .row_op(row_op_e'(row_op)),
        .row_bcast(row_bcast), .row_rlx(row_rlx),
        .col_vld(col_vld), .col_dev(col_dev),
        .wake_vld(wake_vld), .wake_dev(wake_dev),
        .forbid_v(forbid_v), .restr_v(restr_v), .quiet_v(quiet_v), .asleep_v(asleep_v),
        .code(nxt_code), .ign(nxt_ign),
        .arm_stby_v(arm_stby_v), .arm_pwr_v(arm_pwr_v), .wake_v(wake_v)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= VC_NONE;
            ign_q  <= 1'b0;
        end else begin
            code_q <= nxt_code;
            ign_q  <= nxt_ign;
        end
    end

    assign viol      = (code_q != VC_NONE);
    assign viol_code = code_q;
    assign ign       = ign_q;

endmodule

// File: rtl/pwr_gap_chk.sv
module pwr_gap_chk #(
    parameter int DEV_W = 4,
    parameter int N_DEV = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             row_vld,
    input logic             row_bcast,
    input logic             col_vld,
    input logic [DEV_W-1:0] col_dev,
    input logic [N_DEV-1:0] forbid_v,
    input logic [N_DEV-1:0] restr_v,
    input logic [N_DEV-1:0] quiet_v,
    input logic [N_DEV-1:0] asleep_v,
    input logic             viol,
    input logic [2:0]       viol_code,
    input logic             ign
);
    AST_SLOT_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        (col_vld && (|forbid_v)) |=> (viol && viol_code == 3'd1)); // R2

    AST_RESTR_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        (col_vld && restr_v[col_dev] && !(|forbid_v)) |=> (viol && viol_code == 3'd2)); // R5

    AST_QUIET_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        (row_vld && row_bcast && (|quiet_v) && !(col_vld && ((|forbid_v) || restr_v[col_dev])))
        |=> (viol && viol_code == 3'd3)); // R6

    AST_IGN_ASLEEP: assert property (@(posedge clk) disable iff (rst)
        (col_vld && asleep_v[col_dev]) |=> ign); // R7

    AST_VIOL_CAUSED: assert property (@(posedge clk) disable iff (rst)
        viol |-> $past(row_vld || col_vld)); // R11

    AST_QUIET_NESTED: assert property (@(posedge clk) disable iff (rst)
        (quiet_v & ~restr_v) == '0); // R6

endmodule

bind pwr_gap_monitor pwr_gap_chk #(.DEV_W(DEV_W), .N_DEV(N_DEV)) u_chk (
    .clk(clk), .rst(rst), .row_vld(row_vld), .row_bcast(row_bcast),
    .col_vld(col_vld), .col_dev(col_dev),
    .forbid_v(forbid_v), .restr_v(restr_v), .quiet_v(quiet_v), .asleep_v(asleep_v),
    .viol(viol), .viol_code(viol_code), .ign(ign)
);

// File: tb/pwr_gap_monitor_test.sv
`timescale 1ns/1ps
module pwr_gap_monitor_test;
    localparam int DW = 4, ND = 16, TF = 8, RL = 10, QO = 3, QL = 4;

    logic clk = 1'b0;
    logic rst;
    logic row_vld, row_bcast, row_rlx, col_vld, wake_vld;
    logic [DW-1:0] row_dev, col_dev, wake_dev;
    logic [2:0] row_op;
    logic viol, ign;
    logic [2:0] viol_code;

    always #4 clk = ~clk;

    pwr_gap_monitor #(.DEV_W(DW), .T_FRM(TF), .RESTR_LEN(RL), .QUIET_OFS(QO), .QUIET_LEN(QL)) uut (
        .clk(clk), .rst(rst), .row_vld(row_vld), .row_dev(row_dev), .row_op(row_op),
        .row_bcast(row_bcast), .row_rlx(row_rlx), .col_vld(col_vld), .col_dev(col_dev),
        .wake_vld(wake_vld), .wake_dev(wake_dev),
        .viol(viol), .viol_code(viol_code), .ign(ign)
    );

    int tests = 0, fails = 0, cyc = 0;
    bit done = 0;
    string cur_req = "R1";
    int st[ND];
    int t0[ND];

    function automatic bit m_restr(int d);
        return st[d] == 2 && (cyc - t0[d]) >= 1 && (cyc - t0[d]) <= RL;
    endfunction

    task automatic check(string req, int act, int exp, string what);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic step();
        int ecode = 0;
        bit eign, slot = 0, qhit = 0, rdir, rhit, setup, bad, sbad, arm;
        for (int d = 0; d < ND; d++) begin
            if (st[d] == 1 && cyc - t0[d] >= TF) st[d] = 0;
            if (st[d] == 2 && cyc - t0[d] > RL) st[d] = 3;
            if (st[d] == 1 && cyc - t0[d] >= TF-3 && cyc - t0[d] <= TF-1) slot = col_vld;
            if (st[d] == 2 && cyc - t0[d] >= QO+1 && cyc - t0[d] <= QO+QL) qhit = row_vld && row_bcast;
        end
        rdir  = row_vld && !row_bcast;
        rhit  = (rdir && m_restr(row_dev)) || (col_vld && m_restr(col_dev));
        setup = row_vld && (row_rlx || row_op == 4 || row_op == 5);
        bad   = row_bcast || (row_rlx && row_op > 2);
        sbad  = setup && bad && !(rdir && st[row_dev] == 3);
        if (slot) ecode = 1; else if (rhit) ecode = 2; else if (qhit) ecode = 3; else if (sbad) ecode = 4;
        eign = (rdir && st[row_dev] == 3) || (col_vld && st[col_dev] == 3);
        arm  = setup && !bad && rdir && !m_restr(row_dev) && st[row_dev] != 3;
        if (arm) begin st[row_dev] = row_rlx ? 1 : 2; t0[row_dev] = cyc; end
        if (wake_vld && st[wake_dev] == 3) st[wake_dev] = 0;
        @(posedge clk);
        @(negedge clk);
        cyc++;
        check(cur_req, int'(viol), int'(ecode != 0), "viol");
        check(cur_req, int'(viol_code), ecode, "viol_code");
        check(cur_req, int'(ign), int'(eign), "ign");
    endtask

    task automatic quiet_in();
        row_vld = 0; row_dev = '0; row_op = 3'd6; row_bcast = 0; row_rlx = 0;
        col_vld = 0; col_dev = '0; wake_vld = 0; wake_dev = '0;
    endtask

    task automatic row(int d, int op, bit b, bit r);
        quiet_in(); row_vld = 1; row_dev = DW'(d); row_op = 3'(op); row_bcast = b; row_rlx = r;
        step();
    endtask

    task automatic col(int d);
        quiet_in(); col_vld = 1; col_dev = DW'(d); step();
    endtask

    task automatic wake(int d);
        quiet_in(); wake_vld = 1; wake_dev = DW'(d); step();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin quiet_in(); step(); end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int d = 0; d < ND; d++) begin st[d] = 0; t0[d] = 0; end
        quiet_in();
        rst = 1;
        repeat (3) @(negedge clk);
        cur_req = "R1";
        check("R1", int'(viol), 0, "viol in reset");
        check("R1", int'(ign), 0, "ign in reset");
        rst = 0;
        idle(2);

        cur_req = "R2";                      // R2 slots 5..7 hit, any device
        row(2, 0, 0, 1);
        for (int k = 1; k <= 10; k++) col(5);
        cur_req = "R3";                      // R3 same device at frame and after
        row(2, 1, 0, 1);
        idle(3);
        col(6);                              // age 4, legal
        idle(3);
        col(2); col(2);                      // ages 8, 9 legal

        cur_req = "R4";
        row(4, 3, 0, 1);                     // precharge with relax
        for (int k = 1; k <= 8; k++) col(1); // no slot hits: not armed
        row(4, 0, 1, 1);                     // broadcast relax
        row(4, 4, 1, 0);                     // broadcast nap
        row(4, 4, 0, 1);                     // nap opcode with relax
        idle(10);

        cur_req = "R5";
        row(3, 4, 0, 0);                     // nap dev3 at age0
        col(3);                              // age1 restricted
        row(4, 0, 0, 0);                     // other device fine
        col(7);
        cur_req = "R6";
        row(0, 6, 1, 0);                     // age4 quiet
        cur_req = "R10";
        row(3, 5, 0, 0);                     // age5 re-request rejected
        cur_req = "R6";
        row(0, 6, 1, 0); row(0, 6, 1, 0);    // ages 6,7 quiet
        row(0, 6, 1, 0);                     // age8 outside quiet
        cur_req = "R5";
        row(3, 3, 0, 0);                     // age9 restricted
        idle(1);                             // age10
        cur_req = "R7";
        col(3); row(3, 0, 0, 0); row(3, 4, 0, 0); row(3, 0, 0, 1);
        cur_req = "R8";
        wake(6); col(6);
        wake(3); col(3); row(3, 0, 0, 0);

        cur_req = "R9";
        row(1, 2, 0, 1);                     // stby dev1 age0
        row(9, 5, 0, 0);                     // pdn dev9, stby age1
        idle(3);                             // stby ages 2..4
        col(9);                              // slot beats restricted
        quiet_in(); row_vld = 1; row_dev = 4'd9; row_op = 3'd0; row_bcast = 1; row_rlx = 1;
        step();                              // quiet beats bad setup
        cur_req = "R10";
        row(1, 0, 0, 1); idle(4); col(0); col(0); idle(12);
        wake(9);

        cur_req = "R11";                     // mixed traffic, every cycle compared
        for (int i = 0; i < 5000; i++) begin
            int r = $urandom_range(0, 99);
            quiet_in();
            row_vld = (r < 25); row_dev = DW'($urandom_range(0, ND-1));
            row_op = 3'($urandom_range(0, 7)); row_bcast = ($urandom_range(0, 9) == 0);
            row_rlx = ($urandom_range(0, 5) == 0);
            col_vld = ($urandom_range(0, 2) == 0); col_dev = DW'($urandom_range(0, ND-1));
            wake_vld = ($urandom_range(0, 7) == 0); wake_dev = DW'($urandom_range(0, ND-1));
            step();
        end
        idle(2);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule